// File: doc/BRIEF.md
# UART FIFO Trigger and Status Unit

This unit sits between the serial shift engine of a UART and the CPU bus. It holds a 16-entry transmit queue and a 16-entry receive queue, each stored as a plain array. It takes push and pop pulses from both sides, reports how full each queue is, and raises a "transmit queue low" flag and a "receive queue high" flag against thresholds chosen by two encoded trigger fields. Each received character carries a parity tag and a framing tag. The unit keeps running counts of the tagged characters that are still queued.

Software programs an 8-bit control register. It holds the two trigger selects, a reset for each queue, a modem-control enable and an internal loopback switch. Software reads a 16-bit status register. Its event flags are cleared by writing a zero to them, so a write of 1 leaves a flag as it is. The shift logic and the baud generator live elsewhere. The unit only routes the serial lines for loopback.

Top module: `uart_fifo_status`

## Requirements
- R1: Control bits 7:6 select the receive threshold. Codes 0, 1, 2 and 3 give 1, 4, 8 and 14 characters. Status bit 1 is set one cycle after the receive count is at or above the threshold, and a clearing write cannot clear it while that holds.
- R2: Control bits 5:4 select the transmit threshold. Codes 0, 1, 2 and 3 give 8, 4, 2 and 1 characters. Status bit 5 is set one cycle after the transmit count is at or below the threshold, and a clearing write cannot clear it while that holds.
- R3: Each queue is 16 entries deep and first-in first-out. The count output reports the receive count in bits 4:0 and the transmit count in bits 12:8. A push to a full queue is dropped, and a pop from an empty queue does nothing.
- R4: Status bits 15:12 give the number of queued receive characters with a parity tag, and bits 11:8 the number with a framing tag. Both update on push and pop and saturate at 15. Status bit 2 is 1 while the parity count is nonzero, and bit 3 while the framing count is nonzero.
- R5: A status write clears each of bits 7, 6, 5, 4, 1 and 0 whose written value is 0. A written 1 leaves the bit unchanged. Bits 15:8, 3 and 2 ignore writes.
- R6: Status bit 7 sets when an accepted receive push carries either tag. Bit 4 sets on the break input. Bit 0 sets on the idle input when the receive queue is not empty. A set event wins over a clear in the same cycle.
- R7: Status bit 6 sets while the transmitter-idle input is high and the transmit queue is empty.
- R8: While control bit 2 (transmit) or bit 1 (receive) is high, that queue is held empty, its counts read zero, and pushes to it are dropped.
- R9: With control bit 0 high, the receive line output follows the transmit line input and the transmit pin output is held at 1. Otherwise the receive line follows the pin and the transmit pin follows the transmit line. Output modemEn equals control bit 3.
- R10: After reset the control register is 0, both counts are 0 and the status register reads 0x0060.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWr | input | 1 | Write strobe for the control register |
| statWr | input | 1 | Write strobe for the status register |
| cpuWdata | input | 16 | CPU write data |
| txPush | input | 1 | CPU writes a transmit character |
| txPushData | input | 8 | Transmit character |
| txPop | input | 1 | Engine takes the head transmit character |
| txHeadData | output | 8 | Head of the transmit queue |
| rxPush | input | 1 | Engine delivers a received character |
| rxPushData | input | 8 | Received character |
| rxPushPerr | input | 1 | Parity tag of the received character |
| rxPushFerr | input | 1 | Framing tag of the received character |
| rxPop | input | 1 | CPU reads the head receive character |
| rxHeadData | output | 8 | Head of the receive queue |
| brkDetect | input | 1 | Break seen by the receiver |
| rxIdle | input | 1 | Receive line idle pulse |
| txIdle | input | 1 | Transmit shifter idle |
| txLine | input | 1 | Serial output of the transmit engine |
| rxPin | input | 1 | External receive pin |
| rxLine | output | 1 | Serial input to the receive engine |
| txPin | output | 1 | External transmit pin |
| modemEn | output | 1 | Modem-control enable |
| ctrlReg | output | 8 | Control register |
| statusReg | output | 16 | Status register |
| countReg | output | 16 | Queue occupancy counts |

## Verification
The threshold logic is swept with one fill level just below and one at each trigger code of both queues, then cleared with a status write. This separates a correct threshold from one that is off by one and from a code decode that is swapped. Ordering is checked with distinct byte patterns, and overflow with a seventeenth push. Tag accounting uses a mix of parity-only, framing-only and double-tagged characters, then pops only some of them, so a swapped or unretired count shows. A run of sixteen tagged characters shows the saturation. Flag clearing is tried with writes of all ones, a single zero bit, and an event in the same cycle as the clear, which sorts write-one-to-clear and clear-wins errors from correct behaviour.

// File: rtl/ufs_pkg.sv
`timescale 1ns/1ps
package ufs_pkg;
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
  } fifoStrobe_t;

  function automatic logic [4:0] rxThresh(input logic [1:0] code);
    case (code)
      2'd0: return 5'd1;
      2'd1: return 5'd4;
      2'd2: return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  function automatic logic [4:0] txThresh(input logic [1:0] code);
    case (code)
      2'd0: return 5'd8;
      2'd1: return 5'd4;
      2'd2: return 5'd2;
      default: return 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/ufs_fifo.sv
`timescale 1ns/1ps
module ufs_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + AW'(1);
      if (pop)  rdPtr <= rdPtr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wrPtr] <= wdata;
  end

  assign rdata = mem[rdPtr];
endmodule

// File: rtl/ufs_datapath.sv
`timescale 1ns/1ps
module ufs_datapath
  import ufs_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   strb,
  input  logic [DW-1:0] txData,
  input  logic [DW-1:0] rxData,
  input  logic          rxPerr,
  input  logic          rxFerr,
  output logic [DW-1:0] txHead,
  output logic [DW-1:0] rxHead,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic [CW-1:0] perCount,
  output logic [CW-1:0] ferCount
);
  logic [DW+1:0] rxHeadFull;
  logic [1:0]    pushTag, headTag;

  ufs_fifo #(.W(DW), .DEPTH(DEPTH)) txFifo (
    .clk(clk), .rstN(rstN), .clr(strb.txClr), .push(strb.txPush), .pop(strb.txPop),
    .wdata(txData), .rdata(txHead), .count(txCount));

  ufs_fifo #(.W(DW + 2), .DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .clr(strb.rxClr), .push(strb.rxPush), .pop(strb.rxPop),
    .wdata({rxFerr, rxPerr, rxData}), .rdata(rxHeadFull), .count(rxCount));

  assign rxHead  = rxHeadFull[DW-1:0];
  assign pushTag = {rxFerr, rxPerr};
  assign headTag = rxHeadFull[DW+1:DW];

  // one tagged-character counter per tag kind: index 0 parity, 1 framing
  for (genvar g = 0; g < 2; g++) begin : g_err
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cnt <= '0;
      else if (strb.rxClr) cnt <= '0;
      else cnt <= cnt + CW'(strb.rxPush & pushTag[g]) - CW'(strb.rxPop & headTag[g]);
    end
  end

  assign perCount = g_err[0].cnt;
  assign ferCount = g_err[1].cnt;
endmodule

// File: rtl/ufs_control.sv
`timescale 1ns/1ps
module ufs_control
  import ufs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWr,
  input  logic          statWr,
  input  logic [15:0]   cpuWdata,
  input  logic          txPush,
  input  logic          txPop,
  input  logic          rxPush,
  input  logic          rxPop,
  input  logic          rxPerr,
  input  logic          rxFerr,
  input  logic          brkDetect,
  input  logic          rxIdle,
  input  logic          txIdle,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  input  logic [CW-1:0] perCount,
  input  logic [CW-1:0] ferCount,
  output fifoStrobe_t   strb,
  output logic [7:0]    ctrlReg,
  output logic [15:0]   statusReg
);
  localparam logic [7:0] CLEARABLE = 8'hF3;

  logic [CW-1:0] rxThr, txThr;
  logic [7:0]    clrHit;
  logic          errFlag, endFlag, lowFlag, brkFlag, highFlag, readyFlag;

  function automatic logic [3:0] sat4(input logic [CW-1:0] v);
    return (v > CW'(15)) ? 4'hF : v[3:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (ctrlWr) ctrlReg <= cpuWdata[7:0];
  end

  assign rxThr = CW'(rxThresh(ctrlReg[7:6]));
  assign txThr = CW'(txThresh(ctrlReg[5:4]));

  always_comb begin
    strb.txClr  = ctrlReg[2];
    strb.rxClr  = ctrlReg[1];
    strb.txPush = txPush && !strb.txClr && (txCount != CW'(DEPTH));
    strb.txPop  = txPop  && !strb.txClr && (txCount != '0);
    strb.rxPush = rxPush && !strb.rxClr && (rxCount != CW'(DEPTH));
    strb.rxPop  = rxPop  && !strb.rxClr && (rxCount != '0);
  end

  assign clrHit = statWr ? (~cpuWdata[7:0] & CLEARABLE) : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag   <= 1'b0;
      endFlag   <= 1'b1;
      lowFlag   <= 1'b1;
      brkFlag   <= 1'b0;
      highFlag  <= 1'b0;
      readyFlag <= 1'b0;
    end else begin
      errFlag   <= (strb.rxPush && (rxPerr || rxFerr)) || (errFlag && !clrHit[7]);
      endFlag   <= (txIdle && txCount == '0)           || (endFlag && !clrHit[6]);
      lowFlag   <= (txCount <= txThr)                  || (lowFlag && !clrHit[5]);
      brkFlag   <= brkDetect                           || (brkFlag && !clrHit[4]);
      highFlag  <= (rxCount >= rxThr)                  || (highFlag && !clrHit[1]);
      readyFlag <= (rxIdle && rxCount != '0)           || (readyFlag && !clrHit[0]);
    end
  end

  assign statusReg = {sat4(perCount), sat4(ferCount), errFlag, endFlag, lowFlag, brkFlag,
                      (ferCount != '0), (perCount != '0), highFlag, readyFlag};
endmodule

// File: rtl/uart_fifo_status.sv
`timescale 1ns/1ps
module uart_fifo_status
  import ufs_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWr,
  input  logic          statWr,
  input  logic [15:0]   cpuWdata,
  input  logic          txPush,
  input  logic [DW-1:0] txPushData,
  input  logic          txPop,
  output logic [DW-1:0] txHeadData,
  input  logic          rxPush,
  input  logic [DW-1:0] rxPushData,
  input  logic          rxPushPerr,
  input  logic          rxPushFerr,
  input  logic          rxPop,
  output logic [DW-1:0] rxHeadData,
  input  logic          brkDetect,
  input  logic          rxIdle,
  input  logic          txIdle,
  input  logic          txLine,
  input  logic          rxPin,
  output logic          rxLine,
  output logic          txPin,
  output logic          modemEn,
  output logic [7:0]    ctrlReg,
  output logic [15:0]   statusReg,
  output logic [15:0]   countReg
);
  localparam int CW = $clog2(DEPTH) + 1;

  fifoStrobe_t   strb;
  logic [CW-1:0] txCount, rxCount, perCount, ferCount;

  ufs_control #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .statWr(statWr), .cpuWdata(cpuWdata),
    .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
    .rxPerr(rxPushPerr), .rxFerr(rxPushFerr), .brkDetect(brkDetect),
    .rxIdle(rxIdle), .txIdle(txIdle), .txCount(txCount), .rxCount(rxCount),
    .perCount(perCount), .ferCount(ferCount), .strb(strb),
    .ctrlReg(ctrlReg), .statusReg(statusReg));

  ufs_datapath #(.DW(DW), .DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txPushData), .rxData(rxPushData),
    .rxPerr(rxPushPerr), .rxFerr(rxPushFerr), .txHead(txHeadData), .rxHead(rxHeadData),
    .txCount(txCount), .rxCount(rxCount), .perCount(perCount), .ferCount(ferCount));

  assign rxLine   = ctrlReg[0] ? txLine : rxPin;
  assign txPin    = ctrlReg[0] ? 1'b1 : txLine;
  assign modemEn  = ctrlReg[3];
  assign countReg = (16'(txCount) << 8) | 16'(rxCount);
endmodule

// File: rtl/ufs_checker.sv
`timescale 1ns/1ps
module ufs_checker
  import ufs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        rxPush,
  input logic        rxPop,
  input logic        rxPushPerr,
  input logic        txLine,
  input logic        rxLine,
  input logic        txPin,
  input logic [7:0]  ctrlReg,
  input logic [15:0] statusReg,
  input logic [15:0] countReg
);
  localparam int CW = $clog2(DEPTH) + 1;
  logic [CW-1:0] rxC, txC;
  assign rxC = countReg[CW-1:0];
  assign txC = countReg[8 +: CW];

  a_r3_rx_bound: assert property (@(posedge clk) disable iff (!rstN)
    rxC <= CW'(DEPTH));
  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (rxC == CW'(DEPTH) && rxPush && !rxPop && !ctrlReg[1]) |=> rxC == CW'(DEPTH));
  a_r8_rx_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[1] |=> (rxC == '0 && statusReg[15:8] == 8'h00));
  a_r8_tx_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[2] |=> txC == '0);
  a_r1_high_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rxC >= CW'(rxThresh(ctrlReg[7:6]))) |=> statusReg[1]);
  a_r2_low_flag: assert property (@(posedge clk) disable iff (!rstN)
    (txC <= CW'(txThresh(ctrlReg[5:4]))) |=> statusReg[5]);
  a_r4_tag_bound: assert property (@(posedge clk) disable iff (!rstN)
    CW'(statusReg[15:12]) <= rxC);
  a_r6_err_set: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxPushPerr && !ctrlReg[1] && rxC < CW'(DEPTH)) |=> statusReg[7]);
  a_r9_loop: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[0] |-> (rxLine == txLine && txPin));
endmodule

bind uart_fifo_status ufs_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxPop(rxPop), .rxPushPerr(rxPushPerr),
  .txLine(txLine), .rxLine(rxLine), .txPin(txPin), .ctrlReg(ctrlReg),
  .statusReg(statusReg), .countReg(countReg));

// File: tb/uart_fifo_status_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_status_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic ctrlWr = 0, statWr = 0;
  logic [15:0] cpuWdata = '0;
  logic txPush = 0, txPop = 0, rxPush = 0, rxPop = 0;
  logic [7:0] txPushData = '0, rxPushData = '0, txHeadData, rxHeadData;
  logic rxPushPerr = 0, rxPushFerr = 0, brkDetect = 0, rxIdle = 0, txIdle = 0;
  logic txLine = 1, rxPin = 1, rxLine, txPin, modemEn;
  logic [7:0] ctrlReg;
  logic [15:0] statusReg, countReg;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // bits: [15] transmit side, [13:12] trigger code, [8:4] fill level, [0] expected flag
  localparam logic [15:0] VEC [16] = '{
    16'h0000, 16'h0011, 16'h1030, 16'h1041, 16'h2070, 16'h2081, 16'h30D0, 16'h30E1,
    16'h8081, 16'h8090, 16'h9041, 16'h9050, 16'hA021, 16'hA030, 16'hB011, 16'hB020};

  always #2.5 clk = ~clk;

  uart_fifo_status dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wrCtrl(input logic [7:0] v);
    ctrlWr = 1; cpuWdata = {8'h00, v}; tick(); ctrlWr = 0;
  endtask
  task automatic wrStat(input logic [15:0] v);
    statWr = 1; cpuWdata = v; tick(); statWr = 0;
  endtask
  task automatic pushRx(input logic [7:0] d, input logic p, input logic f);
    rxPush = 1; rxPushData = d; rxPushPerr = p; rxPushFerr = f; tick();
    rxPush = 0; rxPushPerr = 0; rxPushFerr = 0;
  endtask
  task automatic pushTx(input logic [7:0] d);
    txPush = 1; txPushData = d; tick(); txPush = 0;
  endtask
  task automatic popRx(); rxPop = 1; tick(); rxPop = 0; endtask
  task automatic popTx(); txPop = 1; tick(); txPop = 0; endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rstN = 1; tick();
    check("R10 ctrl", 32'(ctrlReg), 32'h0);
    check("R10 status", 32'(statusReg), 32'h0060);
    check("R10 count", 32'(countReg), 32'h0);

    // threshold sweep, R1 receive and R2 transmit
    for (int i = 0; i < 16; i++) begin
      logic [1:0] code; logic [4:0] n; logic isTx;
      isTx = VEC[i][15]; code = VEC[i][13:12]; n = VEC[i][8:4];
      wrCtrl(isTx ? {2'b00, code, 4'b0110} : {code, 6'b000110});
      wrCtrl(isTx ? {2'b00, code, 4'b0000} : {code, 6'b000000});
      for (int k = 0; k < 32'(n); k++) begin
        if (isTx) pushTx(8'(k)); else pushRx(8'(k), 1'b0, 1'b0);
      end
      tick(); tick();
      wrStat(16'h00F3 & ~16'h0022);
      tick(); tick();
      if (isTx) begin
        check("R2 low flag", 32'(statusReg[5]), 32'(VEC[i][0]));
        check("R3 tx count field", 32'(countReg[12:8]), 32'(n));
      end else begin
        check("R1 high flag", 32'(statusReg[1]), 32'(VEC[i][0]));
        check("R3 rx count field", 32'(countReg[4:0]), 32'(n));
      end
    end

    // ordering R3
    wrCtrl(8'h06); wrCtrl(8'h00);
    pushRx(8'hA5, 0, 0); pushRx(8'h3C, 0, 0); pushRx(8'hF0, 0, 0);
    check("R3 rx head 1", 32'(rxHeadData), 32'hA5);
    popRx(); check("R3 rx head 2", 32'(rxHeadData), 32'h3C);
    popRx(); check("R3 rx head 3", 32'(rxHeadData), 32'hF0);
    check("R3 rx count after pops", 32'(countReg[4:0]), 32'd1);
    pushTx(8'h11); pushTx(8'h22);
    check("R3 tx head 1", 32'(txHeadData), 32'h11);
    popTx(); check("R3 tx head 2", 32'(txHeadData), 32'h22);

    // overflow and underflow R3
    wrCtrl(8'h02); wrCtrl(8'h00);
    for (int k = 0; k < 16; k++) pushRx(8'(k + 8'h40), 0, 0);
    pushRx(8'h77, 0, 0);
    check("R3 full count", 32'(countReg[4:0]), 32'd16);
    check("R3 full head", 32'(rxHeadData), 32'h40);
    for (int k = 0; k < 15; k++) popRx();
    check("R3 last entry kept", 32'(rxHeadData), 32'h4F);
    popRx(); popRx();
    check("R3 empty pop ignored", 32'(countReg[4:0]), 32'd0);

    // tag counts R4, R5
    wrCtrl(8'h02); wrCtrl(8'h00);
    wrStat(16'h0000);
    for (int k = 0; k < 3; k++) pushRx(8'h01, 1, 0);
    pushRx(8'h02, 0, 1); pushRx(8'h03, 0, 1); pushRx(8'h04, 1, 1);
    check("R4 parity count", 32'(statusReg[15:12]), 32'd4);
    check("R4 framing count", 32'(statusReg[11:8]), 32'd3);
    check("R4 bits 3:2", 32'(statusReg[3:2]), 32'b11);
    check("R6 receive error flag", 32'(statusReg[7]), 32'd1);
    popRx(); popRx(); popRx();
    check("R4 parity after pops", 32'(statusReg[15:12]), 32'd1);
    check("R4 framing after pops", 32'(statusReg[11:8]), 32'd3);
    wrStat(16'h0000);
    check("R5 read-only bits kept", 32'(statusReg[15:8]), 32'h13);
    check("R5 bits 3:2 kept", 32'(statusReg[3:2]), 32'b11);
    check("R5 error flag cleared", 32'(statusReg[7]), 32'd0);

    // saturation R4
    wrCtrl(8'h02); wrCtrl(8'h00);
    for (int k = 0; k < 16; k++) pushRx(8'h55, 1, 0);
    check("R4 saturated", 32'(statusReg[15:12]), 32'd15);
    popRx(); check("R4 fifteen", 32'(statusReg[15:12]), 32'd15);
    popRx(); check("R4 fourteen", 32'(statusReg[15:12]), 32'd14);

    // break, write-one and set-wins R5, R6
    brkDetect = 1; tick(); brkDetect = 0;
    check("R6 break set", 32'(statusReg[4]), 32'd1);
    wrStat(16'hFFFF); check("R5 write one keeps", 32'(statusReg[4]), 32'd1);
    wrStat(16'h00E3); check("R5 write zero clears", 32'(statusReg[4]), 32'd0);
    brkDetect = 1; statWr = 1; cpuWdata = 16'h00E3; tick(); brkDetect = 0; statWr = 0;
    check("R6 set wins over clear", 32'(statusReg[4]), 32'd1);

    // data ready R6
    wrCtrl(8'h02); wrCtrl(8'h00); wrStat(16'h00F2);
    rxIdle = 1; tick(); rxIdle = 0;
    check("R6 idle on empty", 32'(statusReg[0]), 32'd0);
    pushRx(8'h9A, 0, 0);
    rxIdle = 1; tick(); rxIdle = 0;
    check("R6 idle with data", 32'(statusReg[0]), 32'd1);

    // transmit end R7
    wrCtrl(8'h04); wrCtrl(8'h00);
    txIdle = 0; wrStat(16'h00B3); tick();
    check("R7 not idle", 32'(statusReg[6]), 32'd0);
    txIdle = 1; tick(); tick();
    check("R7 idle and empty", 32'(statusReg[6]), 32'd1);
    pushTx(8'h33); tick(); wrStat(16'h00B3); tick();
    check("R7 queue not empty", 32'(statusReg[6]), 32'd0);
    txIdle = 0;

    // FIFO reset hold R8
    wrCtrl(8'h02);
    pushRx(8'h66, 1, 1); tick();
    check("R8 rx held empty", 32'(countReg[4:0]), 32'd0);
    check("R8 tags held zero", 32'(statusReg[15:8]), 32'd0);
    wrCtrl(8'h04); pushTx(8'h44); tick();
    check("R8 tx held empty", 32'(countReg[12:8]), 32'd0);

    // loopback R9
    wrCtrl(8'h01); txLine = 0; rxPin = 1; #1;
    check("R9 loop rx line", 32'(rxLine), 32'd0);
    check("R9 loop pin idle", 32'(txPin), 32'd1);
    wrCtrl(8'h08); #1;
    check("R9 normal rx line", 32'(rxLine), 32'd1);
    check("R9 normal tx pin", 32'(txPin), 32'd0);
    check("R9 modem enable", 32'(modemEn), 32'd1);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule